// File: doc/BRIEF.md
# Three-Voice Wavetable Sound Generator

This block produces three independent 5-bit sound levels for an expansion audio path. Each voice owns a 16-bit countdown divider that paces a 5-bit phase through 32 steps. The phase selects a sample from one of two built-in shapes: a rising ramp or a fixed two-low, two-high square. The sample then passes through a programmable bit mask before it leaves the block. Mixing with other audio sources and any analog stage sit outside this block.

Software reaches the voices through a small register window selected by a 4-bit register number. Each voice has three write registers: control, period low byte and period high byte. Reading a voice's control address returns that voice's live phase. The control register also has a bit that parks the voice at phase zero. This lets software restart a waveform from a known point.

Top module: `wt_audio`

## Requirements
- R1: While `rst` is high at a clock edge, every register returns to zero on that edge. After reset every level output is 0 and every control-address read returns 0.
- R2: While bit 7 (run) of a voice's control register is 0, that voice's phase and divider are held at 0.
- R3: While run is 1, the divider counts down by one each clock. On the clock where it is at 0, it loads the period and the phase steps by one, wrapping from 31 to 0. Starting from the held state, the first step happens on the first clock edge after run is set. After that the phase steps every period+1 clocks.
- R4: With control bit 4 at 0 (ramp), the waveform sample equals the phase.
- R5: With control bit 4 at 1 (square), the sample is 30 when phase bit 1 is set and 0 otherwise. Over the phases this gives 0,0,30,30 repeated.
- R6: A voice's level equals its sample ANDed with {mask,1}. Here mask is control bits 3:0, so the AND value is mask*2+1.
- R7: A read of a voice's control address returns {3'b000, phase}. Every other register number reads as 0.
- R8: The period is {high byte, low byte}. A period write changes nothing in the current countdown and is used at the next reload.
- R9: Voice 0 uses register numbers 4, 5 and 6 (control, period low, period high). Voice 1 uses 8 to 10 and voice 2 uses 12 to 14, in the same order. Writes to numbers 0 to 3, 7, 11 and 15 change no voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one divider step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 4 | Register number for writes and reads |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| level_o | output | 15 | Three 5-bit levels, voice 0 in bits 4:0 |

## Verification
Voice 0 runs a ramp with a short period and a full mask over more than a full cycle of 32 phases. This separates a correct 31-to-0 wrap and step timing from an off-by-one reload. Voice 1 runs a square with period zero and a partial mask, which shows whether the 0,0,30,30 pattern and the mask shift are right. Voice 2 uses a period that needs the high byte and a sparse mask, so that swapped bytes or unshifted mask bits show up. Further patterns rewrite a period mid-count, write to every unused register number, drop run mid-cycle, and sweep reads over all sixteen numbers. These tell a restarting divider, stray decodes and leaky read data apart from the correct behaviour.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int PHASE_W  = 5;
    localparam int LVL_W    = 5;
    localparam int PERIOD_W = 16;
    localparam int SEL_W    = 4;
    localparam logic [LVL_W-1:0] SQUARE_HIGH = 5'd30;

    typedef struct packed {
        logic       run;
        logic [1:0] spare;
        logic       square;
        logic [3:0] mask;
    } voice_ctrl_t;

    function automatic logic [LVL_W-1:0] shape_sample(
        input logic [PHASE_W-1:0] ph,
        input logic               sq
    );
        if (sq)
            return ph[1] ? SQUARE_HIGH : '0;
        return LVL_W'(ph);
    endfunction
endpackage

// File: rtl/wt_voice_regs.sv
module wt_voice_regs
    import wt_pkg::*;
#(
    parameter int CTRL_ADDR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [7:0]          wdata,
    output voice_ctrl_t         ctrl,
    output logic [PERIOD_W-1:0] period
);
    localparam logic [SEL_W-1:0] A_CTRL = SEL_W'(CTRL_ADDR);
    localparam logic [SEL_W-1:0] A_LO   = SEL_W'(CTRL_ADDR + 1);
    localparam logic [SEL_W-1:0] A_HI   = SEL_W'(CTRL_ADDR + 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= '0;
        end else if (wr_en) begin
            if (reg_sel == A_CTRL) ctrl         <= voice_ctrl_t'(wdata);
            if (reg_sel == A_LO)   period[7:0]  <= wdata;
            if (reg_sel == A_HI)   period[15:8] <= wdata;
        end
    end
endmodule

// File: rtl/wt_divider.sv
module wt_divider
    import wt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic [PHASE_W-1:0]  phase
);
    logic [PERIOD_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
            phase <= '0;
        end else if (count == '0) begin
            count <= period;
            phase <= phase + 1'b1;
        end else begin
            count <= count - 1'b1;
        end
    end

    // R2
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0 && count == '0));
    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count != '0) |=> (phase == $past(phase)));
    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count == '0) |=> (phase == PHASE_W'($past(phase) + 1'b1)));
    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count == '0) |=> (count == $past(period)));
endmodule

// File: rtl/wt_shaper.sv
module wt_shaper
    import wt_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    input  voice_ctrl_t        ctrl,
    output logic [LVL_W-1:0]   level
);
    logic [LVL_W-1:0] sample;
    logic [LVL_W-1:0] keep;

    always_comb begin
        sample = shape_sample(phase, ctrl.square);
        keep   = {ctrl.mask, 1'b1};
        level  = sample & keep;
    end

    always_comb begin
        // R6
        mask_bound_chk: assert ((level & ~{ctrl.mask, 1'b1}) == '0);
        // R5
        square_even_chk: assert (!ctrl.square || level[0] == 1'b0);
    end
endmodule

// File: rtl/wt_audio.sv
module wt_audio
    import wt_pkg::*;
#(
    parameter int NUM_VOICES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SEL_W-1:0]            reg_sel,
    input  logic                        wr_en,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    output logic [NUM_VOICES*LVL_W-1:0] level_o
);
    logic [PHASE_W-1:0] phase_v [NUM_VOICES];

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        localparam int BASE = 4 * (v + 1);
        voice_ctrl_t         ctrl;
        logic [PERIOD_W-1:0] period;

        wt_voice_regs #(.CTRL_ADDR(BASE)) u_regs (
            .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
            .wdata(wdata), .ctrl(ctrl), .period(period)
        );
        wt_divider u_div (
            .clk(clk), .rst(rst), .run(ctrl.run), .period(period),
            .phase(phase_v[v])
        );
        wt_shaper u_shape (
            .phase(phase_v[v]), .ctrl(ctrl),
            .level(level_o[v*LVL_W +: LVL_W])
        );
    end

    always_comb begin
        rdata = '0;
        for (int v = 0; v < NUM_VOICES; v++) begin
            if (reg_sel == SEL_W'(4 * (v + 1)))
                rdata = {{(8-PHASE_W){1'b0}}, phase_v[v]};
        end
    end

    always_comb begin
        // R7
        read_idle_chk: assert (reg_sel[1:0] != 2'b00 || reg_sel == '0 ||
                               rdata[7:PHASE_W] == '0);
    end
endmodule

// File: tb/tb_wt_audio.sv
`timescale 1ns/1ps
module tb_wt_audio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [14:0] level_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R1";

    int m_ctrl [3];
    int m_per  [3];
    int m_cnt  [3];
    int m_ph   [3];

    always #2.5 clk = ~clk;

    wt_audio dut (.clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
                  .wdata(wdata), .rdata(rdata), .level_o(level_o));

    // reference model: behavioural, updated at each rising edge
    always @(posedge clk) begin
        for (int v = 0; v < 3; v++) begin
            if (rst) begin
                m_ctrl[v] = 0; m_per[v] = 0; m_cnt[v] = 0; m_ph[v] = 0;
            end else begin
                if (((m_ctrl[v] >> 7) & 1) == 0) begin
                    m_cnt[v] = 0; m_ph[v] = 0;
                end else if (m_cnt[v] == 0) begin
                    m_cnt[v] = m_per[v];
                    m_ph[v]  = (m_ph[v] + 1) % 32;
                end else begin
                    m_cnt[v] = m_cnt[v] - 1;
                end
                if (wr_en) begin
                    if (reg_sel == 4*(v+1))     m_ctrl[v] = wdata;
                    if (reg_sel == 4*(v+1) + 1) m_per[v] = (m_per[v] & 16'hFF00) | wdata;
                    if (reg_sel == 4*(v+1) + 2) m_per[v] = (m_per[v] & 16'h00FF) | (wdata << 8);
                end
            end
        end
    end

    function automatic int exp_level(int v);
        int w;
        if ((m_ctrl[v] >> 4) & 1) w = ((m_ph[v] >> 1) & 1) ? 30 : 0;
        else                      w = m_ph[v];
        return w & (((m_ctrl[v] & 15) << 1) | 1);
    endfunction

    function automatic int exp_rdata();
        for (int v = 0; v < 3; v++)
            if (reg_sel == 4*(v+1)) return m_ph[v];
        return 0;
    endfunction

    task automatic tick();
        @(negedge clk);
        for (int v = 0; v < 3; v++) begin
            int got;
            got = level_o[v*5 +: 5];
            n_chk++;
            // R4 R5 R6 level comparison per voice
            if (got != exp_level(v)) begin
                n_bad++;
                $display("FAIL %s voice %0d level actual %0d expected %0d", tag, v, got, exp_level(v));
            end
        end
        n_chk++;
        // R7 read data comparison
        if (rdata != exp_rdata()) begin
            n_bad++;
            $display("FAIL %s rdata sel %0d actual %0d expected %0d", tag, reg_sel, rdata, exp_rdata());
        end
    endtask

    task automatic wr(input int sel, input int data);
        reg_sel = 4'(sel); wdata = 8'(data); wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input int sel);
        reg_sel = 4'(sel);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        idle(4, 4);
        rst = 1'b0;
        idle(3, 4);
        // R2: voice 0 configured but run clear, phase must stay 0
        tag = "R2";
        wr(5, 3); wr(6, 0); wr(4, 8'h0F);
        idle(10, 4);
        // R3 R4: ramp, full mask, period 3, runs past the wrap
        tag = "R3_R4";
        wr(4, 8'h8F);
        idle(150, 4);
        // R5 R6: square on voice 1, period 0, mask 7
        tag = "R5_R6";
        wr(9, 0); wr(10, 0); wr(8, 8'h97);
        idle(40, 8);
        // R8 R9: voice 2 needs high byte, sparse mask
        tag = "R8_R9";
        wr(13, 2); wr(14, 1); wr(12, 8'h85);
        idle(600, 12);
        // R8: rewrite period mid-count, no restart
        tag = "R8";
        wr(4, 8'h8F); idle(2, 4);
        wr(5, 10);
        idle(60, 4);
        // R9: unused register numbers change nothing
        tag = "R9";
        wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
        wr(7, 8'hFF); wr(11, 8'hFF); wr(15, 8'hFF);
        idle(30, 8);
        // R2: drop run mid-cycle
        tag = "R2";
        wr(4, 8'h0F);
        idle(20, 4);
        wr(8, 8'h17);
        idle(5, 8);
        // R7: sweep reads across all register numbers
        tag = "R7";
        wr(4, 8'h9F);
        for (int s = 0; s < 16; s++) idle(3, s);
        // R1: reset again mid-run
        tag = "R1";
        rst = 1'b1; idle(2, 12); rst = 1'b0; idle(3, 12);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule